// File: doc/BRIEF.md
# Abstract Command Controller

This block takes 32-bit abstract commands written over a small register port, together with a bank of 32-bit argument registers. It decodes the command type in the top byte. For the register-access type it checks the option fields and the state of the selected hart, then runs a single register transfer through a request/response port to that hart. While the transfer runs it holds a busy flag. When a read completes, the block places the result in the argument registers in the same clock edge that clears busy.

Failures are recorded in a sticky 3-bit error code. The first error recorded wins. While the code is nonzero, later commands are refused, so nothing runs after a failing command. Software clears the code by writing ones to the bits it wants to clear. The register port is also how software writes arguments, reads results, and polls busy and the error code.

Top module: `abs_cmd_ctrl`

## Requirements
- R1: After reset, busy is 0, the error code is 0, no hart request is raised and every argument register reads 0.
- R2: A command whose bits 31:24 are not 0x00 (register access) sets the error code to 2 and never raises a hart request.
- R3: A register-access command is unsupported, giving error code 2 and no hart request, when any of these hold: bit 18 (post-execute) is set, reserved bit 23 or bit 19 is set, or the size field in bits 22:20 is neither 2 (32-bit) nor 3 (64-bit).
- R4: A valid register-access command with bit 17 (transfer) set and bit 16 (write) clear raises busy and a hart request carrying regno = bits 15:0 and write = 0 on the cycle after the command write. A 32-bit read result lands in argument 0 on the same edge that clears busy, and argument 1 is left unchanged.
- R5: A 64-bit read places result bits 31:0 in argument 0 and bits 63:32 in argument 1.
- R6: For a write (bit 16 set), the request data is {argument 1, argument 0} for size 3 and {32'h0, argument 0} for size 2. Nothing is written back into the argument registers.
- R7: A hart response flagged as an exception ends the command with error code 3 and leaves the argument registers unchanged.
- R8: A transfer command issued while the hart is not halted, or is unavailable, sets error code 4 and raises no hart request.
- R9: If the hart becomes unavailable while a transfer is outstanding, the command ends on the next edge with busy low and error code 4.
- R10: While the error code is nonzero, command writes are ignored: busy stays low and no request is raised.
- R11: A command or argument write that arrives while busy is dropped. It sets the error code to 1 if the code was 0, and the running command still completes.
- R12: Writing to the status register (address 14) clears each error-code bit whose matching bit in wdata[2:0] is 1. Status reads return busy at bit 4 and the error code in bits 2:0.
- R13: A supported register-access command with bit 17 clear completes at once, with no hart request, no busy and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: arguments at 0..NUM_DATA-1, status at 14, command at 15 |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address (same map) |
| rd_data | output | 32 | Combinational read data; the command address reads 0 |
| busy | output | 1 | A hart transfer is outstanding |
| cmd_err | output | 3 | Sticky error code |
| hart_halted | input | 1 | Selected hart is halted |
| hart_avail | input | 1 | Selected hart is available |
| hart_req | output | 1 | Register transfer request, held until response or abort |
| hart_req_write | output | 1 | 1 for a write transfer |
| hart_req_wide | output | 1 | 1 for a 64-bit transfer |
| hart_req_regno | output | 16 | Register number |
| hart_req_wdata | output | 64 | Write data |
| hart_rsp_valid | input | 1 | One-cycle response strobe |
| hart_rsp_exc | input | 1 | Response carries an exception |
| hart_rsp_rdata | input | 64 | Read data returned |

## Verification
On every cycle, the assertions check the following: the request fields stay stable while busy, busy only rises when the error code was 0 and the hart was halted and available, busy only falls after a response or a loss of availability, the error code never takes a value above 4, and the argument registers do not change while busy except on a result write. The bench's scenarios are needed for the rest. They show which error code each failing command produces, where the two words of a 64-bit result land, the data presented on a write, the first-error-wins rule when a busy violation is followed by the command's own completion, and the partial clearing of the error code.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int CMD_W     = 32;
    localparam int WORD_W    = 32;
    localparam int REGNO_W   = 16;
    localparam int TYPE_HI   = 31;
    localparam int TYPE_LO   = 24;
    localparam int RSV_HI    = 23;
    localparam int SIZE_HI   = 22;
    localparam int SIZE_LO   = 20;
    localparam int RSV_LO    = 19;
    localparam int POSTX_BIT = 18;
    localparam int XFER_BIT  = 17;
    localparam int WRITE_BIT = 16;

    localparam logic [7:0] TYPE_REGACC = 8'h00;
    localparam logic [2:0] SIZE_32     = 3'd2;
    localparam logic [2:0] SIZE_64     = 3'd3;

    localparam logic [2:0] ERR_NONE  = 3'd0;
    localparam logic [2:0] ERR_BUSY  = 3'd1;
    localparam logic [2:0] ERR_UNSUP = 3'd2;
    localparam logic [2:0] ERR_EXC   = 3'd3;
    localparam logic [2:0] ERR_HALT  = 3'd4;

    typedef enum logic {
        ST_IDLE,
        ST_ACCESS
    } acc_state_e;

    typedef struct packed {
        logic               type_ok;
        logic               opt_ok;
        logic               xfer;
        logic               write;
        logic               wide;
        logic [REGNO_W-1:0] regno;
    } cmd_dec_t;

    typedef struct packed {
        acc_state_e         state;
        logic [2:0]         err;
        logic               write;
        logic               wide;
        logic [REGNO_W-1:0] regno;
    } fsm_regs_t;

endpackage

// File: rtl/acc_cmd_decode.sv
module acc_cmd_decode
    import acc_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_word,
    output cmd_dec_t         dec
);

    logic [2:0] size_f;

    always_comb begin
        size_f      = cmd_word[SIZE_HI:SIZE_LO];
        dec.type_ok = (cmd_word[TYPE_HI:TYPE_LO] == TYPE_REGACC);
        dec.opt_ok  = !cmd_word[POSTX_BIT] && !cmd_word[RSV_HI] && !cmd_word[RSV_LO]
                      && ((size_f == SIZE_32) || (size_f == SIZE_64));
        dec.xfer    = cmd_word[XFER_BIT];
        dec.write   = cmd_word[WRITE_BIT];
        dec.wide    = (size_f == SIZE_64);
        dec.regno   = cmd_word[REGNO_W-1:0];
    end

endmodule

// File: rtl/acc_data_bank.sv
module acc_data_bank
    import acc_pkg::*;
#(
    parameter int NUM_DATA = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic                lock,
    input  logic                res_we,
    input  logic                res_wide,
    input  logic [2*WORD_W-1:0] res_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_word,
    output logic [WORD_W-1:0]   arg_lo,
    output logic [WORD_W-1:0]   arg_hi
);

    typedef logic [NUM_DATA-1:0][WORD_W-1:0] bank_t;

    bank_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (wr_en && !lock && (wr_addr == ADDR_W'(i))) begin
                regs_d[i] = wr_data;
            end
        end
        if (res_we) begin
            regs_d[0] = res_data[WORD_W-1:0];
            if (res_wide) begin
                regs_d[1] = res_data[2*WORD_W-1:WORD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_word = regs_q[i];
            end
        end
    end

    assign arg_lo = regs_q[0];
    assign arg_hi = regs_q[1];

    // R11: arguments hold while a transfer is outstanding, except for the result write
    p_args_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock) && !$past(res_we)) |-> $stable(regs_q))
        else $error("argument bank changed while locked");

endmodule

// File: rtl/acc_cmd_fsm.sv
module acc_cmd_fsm
    import acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic               data_wr,
    input  logic               stat_wr,
    input  logic [2:0]         stat_clr,
    input  cmd_dec_t           dec,
    input  logic               halted,
    input  logic               avail,
    input  logic               rsp_valid,
    input  logic               rsp_exc,
    output logic               busy,
    output logic [2:0]         err,
    output logic               req_write,
    output logic               req_wide,
    output logic [REGNO_W-1:0] req_regno,
    output logic               res_we,
    output logic               res_wide
);

    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        res_we   = 1'b0;
        res_wide = 1'b0;

        if (stat_wr) begin
            r_d.err = r_q.err & ~stat_clr;
        end

        unique case (r_q.state)
            ST_IDLE: begin
                if (cmd_wr && (r_q.err == ERR_NONE)) begin
                    if (!dec.type_ok || !dec.opt_ok) begin
                        r_d.err = ERR_UNSUP;
                    end else if (dec.xfer) begin
                        if (!halted || !avail) begin
                            r_d.err = ERR_HALT;
                        end else begin
                            r_d.state = ST_ACCESS;
                            r_d.write = dec.write;
                            r_d.wide  = dec.wide;
                            r_d.regno = dec.regno;
                        end
                    end
                end
            end
            ST_ACCESS: begin
                if ((cmd_wr || data_wr) && (r_q.err == ERR_NONE)) begin
                    r_d.err = ERR_BUSY;
                end
                if (!avail) begin
                    if (r_d.err == ERR_NONE) begin
                        r_d.err = ERR_HALT;
                    end
                    r_d.state = ST_IDLE;
                end else if (rsp_valid) begin
                    if (rsp_exc) begin
                        if (r_d.err == ERR_NONE) begin
                            r_d.err = ERR_EXC;
                        end
                    end else if (!r_q.write) begin
                        res_we   = 1'b1;
                        res_wide = r_q.wide;
                    end
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, err: ERR_NONE, write: 1'b0, wide: 1'b0, regno: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.state == ST_ACCESS);
    assign err       = r_q.err;
    assign req_write = r_q.write;
    assign req_wide  = r_q.wide;
    assign req_regno = r_q.regno;

    // R4: request fields do not move while the transfer is outstanding
    p_req_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(req_regno) && $stable(req_write) && $stable(req_wide)))
        else $error("request fields changed mid-transfer");

    // R10: a transfer only starts from a clear error code
    p_no_start_on_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(r_q.err) == ERR_NONE))
        else $error("transfer started with error pending");

    // R8: a transfer only starts against a halted, available hart
    p_start_needs_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(halted && avail))
        else $error("transfer started on a hart that was not halted");

    // R9: busy only ends on a response or a loss of availability
    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(rsp_valid) || !$past(avail)))
        else $error("busy dropped without cause");

    // R3: the error code stays inside the defined set
    p_err_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.err <= ERR_HALT)
        else $error("illegal error code");

endmodule

// File: rtl/abs_cmd_ctrl.sv
module abs_cmd_ctrl
    import acc_pkg::*;
#(
    parameter int NUM_DATA = 4,
    parameter int ADDR_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [WORD_W-1:0]   rd_data,
    output logic                busy,
    output logic [2:0]          cmd_err,
    input  logic                hart_halted,
    input  logic                hart_avail,
    output logic                hart_req,
    output logic                hart_req_write,
    output logic                hart_req_wide,
    output logic [REGNO_W-1:0]  hart_req_regno,
    output logic [2*WORD_W-1:0] hart_req_wdata,
    input  logic                hart_rsp_valid,
    input  logic                hart_rsp_exc,
    input  logic [2*WORD_W-1:0] hart_rsp_rdata
);

    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'((1 << ADDR_W) - 2);
    localparam logic [ADDR_W-1:0] CMD_ADDR  = ADDR_W'((1 << ADDR_W) - 1);
    localparam logic [ADDR_W-1:0] DATA_END  = ADDR_W'(NUM_DATA);

    cmd_dec_t          dec;
    logic              cmd_wr, data_wr, stat_wr;
    logic              res_we, res_wide;
    logic [WORD_W-1:0] bank_rd, arg_lo, arg_hi;

    assign cmd_wr  = wr_en && (wr_addr == CMD_ADDR);
    assign stat_wr = wr_en && (wr_addr == STAT_ADDR);
    assign data_wr = wr_en && (wr_addr < DATA_END);

    acc_cmd_decode u_dec (
        .cmd_word (wr_data),
        .dec      (dec)
    );

    acc_cmd_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .data_wr   (data_wr),
        .stat_wr   (stat_wr),
        .stat_clr  (wr_data[2:0]),
        .dec       (dec),
        .halted    (hart_halted),
        .avail     (hart_avail),
        .rsp_valid (hart_rsp_valid),
        .rsp_exc   (hart_rsp_exc),
        .busy      (busy),
        .err       (cmd_err),
        .req_write (hart_req_write),
        .req_wide  (hart_req_wide),
        .req_regno (hart_req_regno),
        .res_we    (res_we),
        .res_wide  (res_wide)
    );

    acc_data_bank #(
        .NUM_DATA (NUM_DATA),
        .ADDR_W   (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .lock     (busy),
        .res_we   (res_we),
        .res_wide (res_wide),
        .res_data (hart_rsp_rdata),
        .rd_addr  (rd_addr),
        .rd_word  (bank_rd),
        .arg_lo   (arg_lo),
        .arg_hi   (arg_hi)
    );

    assign hart_req       = busy;
    assign hart_req_wdata = {(hart_req_wide ? arg_hi : '0), arg_lo};

    always_comb begin
        if (rd_addr == STAT_ADDR) begin
            rd_data = {27'b0, busy, 1'b0, cmd_err};
        end else if (rd_addr == CMD_ADDR) begin
            rd_data = '0;
        end else begin
            rd_data = bank_rd;
        end
    end

    // R2: no hart request can follow an unknown command type
    p_bad_type_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !dec.type_ok) |=> !hart_req)
        else $error("request raised for unknown command type");

endmodule

// File: tb/tb_abs_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_abs_cmd_ctrl;

    localparam int ND   = 4;
    localparam int AW   = 4;
    localparam logic [AW-1:0] STAT = 4'd14;
    localparam logic [AW-1:0] CMD  = 4'd15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        busy;
    logic [2:0]  cmd_err;
    logic        h_halted = 1'b1;
    logic        h_avail = 1'b1;
    logic        hart_req, hart_req_write, hart_req_wide;
    logic [15:0] hart_req_regno;
    logic [63:0] hart_req_wdata;
    logic        rsp_valid = 1'b0;
    logic        rsp_exc = 1'b0;
    logic [63:0] rsp_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int h_delay = 0;
    int hcnt = 0;
    int cyc = 0;
    bit req_seen = 0;
    bit model_on = 0;

    // reference model state
    int          m_busy, m_err, m_wr, m_wide;
    logic [15:0] m_regno;
    logic [63:0] m_wdata;
    logic [31:0] m_data [ND];

    always #5 clk = ~clk;

    abs_cmd_ctrl #(.NUM_DATA(ND), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .cmd_err(cmd_err),
        .hart_halted(h_halted), .hart_avail(h_avail), .hart_req(hart_req),
        .hart_req_write(hart_req_write), .hart_req_wide(hart_req_wide),
        .hart_req_regno(hart_req_regno), .hart_req_wdata(hart_req_wdata),
        .hart_rsp_valid(rsp_valid), .hart_rsp_exc(rsp_exc), .hart_rsp_rdata(rsp_rdata)
    );

    function automatic logic [63:0] pat(input logic [15:0] r);
        return {16'hA5A5, r, 16'h5A5A, ~r};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_wr = 0; m_wide = 0; m_regno = 0; m_wdata = 0;
            foreach (m_data[i]) m_data[i] = 0;
        end else begin
            int e;
            int sz;
            e  = m_err;
            sz = wr_data[22:20];
            if (wr_en && wr_addr == STAT) e = e & ~int'(wr_data[2:0]);
            if (m_busy == 0) begin
                if (wr_en && wr_addr == CMD && m_err == 0) begin
                    if (wr_data[31:24] != 0 || wr_data[23] || wr_data[19] || wr_data[18]
                        || (sz != 2 && sz != 3)) e = 2;
                    else if (wr_data[17]) begin
                        if (!h_halted || !h_avail) e = 4;
                        else begin
                            m_busy = 1; m_wr = wr_data[16]; m_wide = (sz == 3);
                            m_regno = wr_data[15:0];
                            m_wdata = {(sz == 3) ? m_data[1] : 32'h0, m_data[0]};
                        end
                    end
                end
                if (wr_en && wr_addr < ND) m_data[wr_addr] = wr_data;
            end else begin
                if (wr_en && (wr_addr == CMD || wr_addr < ND) && m_err == 0) e = 1;
                if (!h_avail) begin
                    if (e == 0) e = 4;
                    m_busy = 0;
                end else if (rsp_valid) begin
                    if (rsp_exc) begin
                        if (e == 0) e = 3;
                    end else if (m_wr == 0) begin
                        m_data[0] = rsp_rdata[31:0];
                        if (m_wide != 0) m_data[1] = rsp_rdata[63:32];
                    end
                    m_busy = 0;
                end
            end
            m_err = e;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (hart_req) req_seen = 1;
        if (model_on) begin
            chk("R4 busy", 64'(busy), 64'(m_busy));
            chk("R12 err", 64'(cmd_err), 64'(m_err));
            chk("R4 req", 64'(hart_req), 64'(m_busy));
            if (m_busy != 0) begin
                chk("R4 regno", 64'(hart_req_regno), 64'(m_regno));
                chk("R6 write", 64'(hart_req_write), 64'(m_wr));
                chk("R6 wdata", hart_req_wdata, m_wdata);
            end
        end
    end

    // hart responder
    always @(negedge clk) begin
        #1;
        rsp_valid = 1'b0;
        rsp_exc   = 1'b0;
        if (hart_req) begin
            if (hcnt == h_delay) begin
                rsp_valid = 1'b1;
                rsp_rdata = pat(hart_req_regno);
                rsp_exc   = (hart_req_regno == 16'h0BAD);
                hcnt = 0;
            end else hcnt++;
        end else hcnt = 0;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 500 && busy; k++) @(negedge clk);
    endtask

    task automatic chk_rd(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
        rd_addr = a; #1;
        chk(tag, 64'(rd_data), 64'(exp));
    endtask

    task automatic clear_err();
        wr(STAT, 32'h7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        model_on = 1;

        // R1 reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 err", 64'(cmd_err), 0);
        chk("R1 req", 64'(hart_req), 0);
        chk_rd("R1 data0", 4'd0, 32'h0);
        chk_rd("R1 data3", 4'd3, 32'h0);

        // R4 32-bit read
        wr(4'd1, 32'hDEAD0001);
        h_delay = 2;
        wr(CMD, 32'h0022_1005);
        chk("R4 req", 64'(hart_req), 1);
        chk("R4 regno", 64'(hart_req_regno), 64'h1005);
        chk("R4 write", 64'(hart_req_write), 0);
        wait_idle();
        chk_rd("R4 data0", 4'd0, pat(16'h1005) >> 0);
        chk_rd("R4 data1 kept", 4'd1, 32'hDEAD0001);
        chk_rd("R12 status", STAT, 32'h0);

        // R5 64-bit read
        wr(CMD, 32'h0032_1010);
        wait_idle();
        chk_rd("R5 low", 4'd0, pat(16'h1010) >> 0);
        chk_rd("R5 high", 4'd1, 32'(pat(16'h1010) >> 32));

        // R6 writes
        wr(4'd0, 32'h11223344);
        wr(4'd1, 32'h55667788);
        wr(CMD, 32'h0033_1002);
        chk("R6 wdata64", hart_req_wdata, 64'h55667788_11223344);
        chk("R6 write", 64'(hart_req_write), 1);
        wait_idle();
        chk_rd("R6 data0 kept", 4'd0, 32'h11223344);
        wr(CMD, 32'h0023_1003);
        chk("R6 wdata32", hart_req_wdata, 64'h00000000_11223344);
        wait_idle();

        // R7 exception
        wr(CMD, 32'h0022_0BAD);
        wait_idle();
        chk("R7 err", 64'(cmd_err), 3);
        chk_rd("R7 data0 kept", 4'd0, 32'h11223344);
        clear_err();
        chk("R12 cleared", 64'(cmd_err), 0);

        // R2 unknown type
        req_seen = 0;
        wr(CMD, 32'h0222_1005);
        @(negedge clk);
        chk("R2 err", 64'(cmd_err), 2);
        chk("R2 no req", 64'(req_seen), 0);
        clear_err();

        // R3 unsupported options
        req_seen = 0;
        wr(CMD, 32'h0026_1005);
        chk("R3 postexec", 64'(cmd_err), 2);
        clear_err();
        wr(CMD, 32'h0042_1005);
        chk("R3 size", 64'(cmd_err), 2);
        clear_err();
        wr(CMD, 32'h00A2_1005);
        chk("R3 reserved", 64'(cmd_err), 2);
        @(negedge clk);
        chk("R3 no req", 64'(req_seen), 0);

        // R10 refused while error pending, R12 partial clear
        req_seen = 0;
        wr(CMD, 32'h0022_1005);
        @(negedge clk);
        chk("R10 no busy", 64'(busy), 0);
        chk("R10 no req", 64'(req_seen), 0);
        wr(STAT, 32'h1);
        chk_rd("R12 partial", STAT, 32'h2);
        wr(STAT, 32'h2);
        chk("R12 clear", 64'(cmd_err), 0);

        // R8 hart not halted / unavailable
        req_seen = 0;
        h_halted = 1'b0;
        wr(CMD, 32'h0022_1005);
        chk("R8 not halted", 64'(cmd_err), 4);
        clear_err();
        h_halted = 1'b1; h_avail = 1'b0;
        wr(CMD, 32'h0022_1005);
        chk("R8 unavail", 64'(cmd_err), 4);
        @(negedge clk);
        chk("R8 no req", 64'(req_seen), 0);
        h_avail = 1'b1;
        clear_err();

        // R13 no transfer
        req_seen = 0;
        wr(CMD, 32'h0020_1005);
        @(negedge clk);
        chk("R13 no req", 64'(req_seen), 0);
        chk("R13 no err", 64'(cmd_err), 0);

        // R11 writes while busy
        wr(4'd2, 32'h22222222);
        h_delay = 5;
        wr(CMD, 32'h0022_1007);
        wr(CMD, 32'h0022_1008);
        chk("R11 err busy", 64'(cmd_err), 1);
        chk("R11 still busy", 64'(busy), 1);
        wr(4'd2, 32'h33333333);
        wait_idle();
        chk_rd("R11 data2 kept", 4'd2, 32'h22222222);
        chk_rd("R11 result", 4'd0, pat(16'h1007) >> 0);
        chk("R11 first err", 64'(cmd_err), 1);
        clear_err();

        // R9 unavailable mid-transfer
        h_delay = 50;
        wr(CMD, 32'h0022_1009);
        repeat (3) @(negedge clk);
        #1 h_avail = 1'b0;
        @(negedge clk);
        chk("R9 busy low", 64'(busy), 0);
        chk("R9 err", 64'(cmd_err), 4);
        #1 h_avail = 1'b1;
        clear_err();
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule